// File: doc/BRIEF.md
# Control Block List Manager

This block owns a small on-chip table of command control blocks and keeps two linked structures over it. A disconnected list holds blocks whose transactions are parked, linked both forward and backward so that any member can be taken out in constant time. A free list holds unused blocks, linked forward only, and behaves as a stack. One reserved index value (0xFF by default) stands for "no entry" in both list heads and in every link field.

A sequencer or controller issues one command at a time through a valid/ready handshake. A command can link a block in at the front of the disconnected list, unlink it from anywhere in that list, return it to the free stack, allocate a block, search the disconnected list, or read back a table entry. A search walks one table entry per clock. Allocation prefers the free stack. When the free stack is empty it takes the front of the disconnected list instead, first raising a one-cycle page-out request with that block's tag so that its contents can be saved elsewhere. Every command ends with a single response pulse that carries an index and a hit flag.

Top module: `scb_list_mgr`

## Requirements
- R1: After reset the disconnected head is 0xFF, the free head is 0, each entry i links forward to i+1, and the last entry links forward to 0xFF, so successive allocations return 0, 1, 2 and so on.
- R2: `cmdReady` is high only while no command is in progress. Each accepted command yields exactly one single-cycle `rspValid` pulse. Opcodes are 0 insert, 1 remove, 2 search, 3 free, 4 allocate, 5 read. Any other opcode returns hit 0 and index 0xFF and leaves the table unchanged.
- R3: Insert writes the tag, identifier and control fields into entry `cmdIdx`, sets its previous link to 0xFF and its next link to the old disconnected head, points the old head's previous link at `cmdIdx` when that head is not null, and makes `cmdIdx` the new head.
- R4: Remove points the successor's previous link (when next is not null) at the removed entry's previous link. When the removed entry's previous link is null, the disconnected head takes the removed entry's next link. Otherwise the predecessor's next link takes it.
- R5: A search whose `cmdTag` is 0xFF compares the identifier field against `cmdIdent`, starting with the entry at `cmdIdx` itself.
- R6: A search whose `cmdTag` is not 0xFF compares the tag field only, following next links from `cmdIdx`.
- R7: A search returns the matching index with hit 1. When it reaches a null next link without a match, or starts at 0xFF, it returns 0xFF with hit 0.
- R8: A search examines one entry per cycle. A match at the k-th entry visited (k from 0) responds k+3 cycles after acceptance, and no search response comes later than NUM_ENTRIES+2 cycles after acceptance.
- R9: Free pushes `cmdIdx` on the free stack: its next link takes the old free head, its tag becomes 0xFF, and it becomes the free head.
- R10: Allocate returns the free head with hit 1 when the free stack is not empty, and the free head advances to that entry's next link.
- R11: With an empty free stack and a non-empty disconnected list, allocate pulses `pageOutValid` with the head's tag in the cycle before the response, then unlinks that head as in R4 and returns its index with hit 1.
- R12: With both lists empty, allocate returns 0xFF with hit 0 and raises no page-out.
- R13: Read returns the tag, identifier, control, next and previous fields of entry `cmdIdx` with hit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Manager idle and accepting a command |
| cmdOp | input | 3 | Command opcode |
| cmdIdx | input | 8 | Entry index, or start index for a search |
| cmdTag | input | 8 | Tag for insert, or search key (0xFF selects identifier search) |
| cmdIdent | input | 8 | Identifier for insert, or identifier search key |
| cmdCtrl | input | 8 | Control byte written by insert |
| rspValid | output | 1 | One-cycle completion pulse |
| rspHit | output | 1 | 1 when the result index is a real entry |
| rspIdx | output | 8 | Result index, 0xFF on a miss |
| rspTag | output | 8 | Tag field of the entry read |
| rspIdent | output | 8 | Identifier field of the entry read |
| rspCtrl | output | 8 | Control field of the entry read |
| rspNext | output | 8 | Next link of the entry read |
| rspPrev | output | 8 | Previous link of the entry read |
| pageOutValid | output | 1 | Request to save a block taken from the disconnected list |
| pageOutTag | output | 8 | Tag of the block to save |
| discHeadOut | output | 8 | Current disconnected-list head |
| freeHeadOut | output | 8 | Current free-stack head |

## Verification
The hardest state to reach from the ports is allocation falling back to the disconnected list. It needs the whole free stack drained while the disconnected list still holds blocks. The stimulus takes several blocks, links them in and unlinks some from the middle and the front. It returns one block to the free stack and allocates it again, then allocates until the free head reads 0xFF. Only after that does it allocate twice more from the disconnected list, checking the page-out tag, its cycle relative to the response, and the relinked neighbour, before a final allocation against two empty lists.

// File: rtl/scb_list_pkg.sv
package scb_list_pkg;

  parameter int DW = 8;

  typedef enum logic [2:0] {
    OP_INSERT = 3'd0,
    OP_REMOVE = 3'd1,
    OP_SEARCH = 3'd2,
    OP_FREE   = 3'd3,
    OP_ALLOC  = 3'd4,
    OP_READ   = 3'd5
  } scbOp_e;

  typedef struct packed {
    logic [DW-1:0] tag;
    logic [DW-1:0] ident;
    logic [DW-1:0] ctrl;
    logic [DW-1:0] next;
    logic [DW-1:0] prev;
  } scbEntry_t;

  // Strobes from the control to the table: one whole-entry write, one tag
  // write, two single-link writes and the two head registers.
  typedef struct packed {
    logic          entWr;
    logic [DW-1:0] entIdx;
    scbEntry_t     entVal;
    logic          tagWr;
    logic [DW-1:0] tagIdx;
    logic [DW-1:0] tagVal;
    logic          linkAEn;
    logic          linkAIsNext;
    logic [DW-1:0] linkAIdx;
    logic [DW-1:0] linkAVal;
    logic          linkBEn;
    logic          linkBIsNext;
    logic [DW-1:0] linkBIdx;
    logic [DW-1:0] linkBVal;
    logic          discHeadWr;
    logic [DW-1:0] discHeadVal;
    logic          freeHeadWr;
    logic [DW-1:0] freeHeadVal;
  } dpStrobe_t;

endpackage

// File: rtl/scb_table.sv
module scb_table
  import scb_list_pkg::*;
#(
  parameter int            NUM_ENTRIES = 16,
  parameter logic [DW-1:0] NULL_IDX    = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [DW-1:0] rdIdxA,
  input  logic [DW-1:0] rdIdxB,
  output scbEntry_t     rdEntA,
  output scbEntry_t     rdEntB,
  output logic [DW-1:0] discHead,
  output logic [DW-1:0] freeHead
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  scbEntry_t tblQ [NUM_ENTRIES];
  scbEntry_t tblD [NUM_ENTRIES];

  function automatic scbEntry_t resetEntry(input int pos);
    scbEntry_t e;
    e.tag   = NULL_IDX;
    e.ident = NULL_IDX;
    e.ctrl  = '0;
    e.prev  = NULL_IDX;
    e.next  = (pos == NUM_ENTRIES - 1) ? NULL_IDX : DW'(pos + 1);
    return e;
  endfunction

  function automatic scbEntry_t updateEntry(input scbEntry_t cur,
                                            input logic [IDX_W-1:0] me,
                                            input dpStrobe_t s);
    scbEntry_t e;
    e = cur;
    if (s.entWr && s.entIdx[IDX_W-1:0] == me) e = s.entVal;
    if (s.tagWr && s.tagIdx[IDX_W-1:0] == me) e.tag = s.tagVal;
    if (s.linkAEn && s.linkAIdx[IDX_W-1:0] == me) begin
      if (s.linkAIsNext) e.next = s.linkAVal;
      else               e.prev = s.linkAVal;
    end
    if (s.linkBEn && s.linkBIdx[IDX_W-1:0] == me) begin
      if (s.linkBIsNext) e.next = s.linkBVal;
      else               e.prev = s.linkBVal;
    end
    return e;
  endfunction

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEnt
    assign tblD[g] = updateEntry(tblQ[g], IDX_W'(g), strb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tblQ[i] <= resetEntry(i);
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) tblQ[i] <= tblD[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discHead <= NULL_IDX;
      freeHead <= '0;
    end else begin
      if (strb.discHeadWr) discHead <= strb.discHeadVal;
      if (strb.freeHeadWr) freeHead <= strb.freeHeadVal;
    end
  end

  assign rdEntA = tblQ[rdIdxA[IDX_W-1:0]];
  assign rdEntB = tblQ[rdIdxB[IDX_W-1:0]];

endmodule

// File: rtl/scb_list_ctrl.sv
module scb_list_ctrl
  import scb_list_pkg::*;
#(
  parameter int            NUM_ENTRIES = 16,
  parameter logic [DW-1:0] NULL_IDX    = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic [2:0]    cmdOp,
  input  logic [DW-1:0] cmdIdx,
  input  logic [DW-1:0] cmdTag,
  input  logic [DW-1:0] cmdIdent,
  input  logic [DW-1:0] cmdCtrl,
  input  scbEntry_t     rdEntA,
  input  scbEntry_t     rdEntB,
  input  logic [DW-1:0] discHead,
  input  logic [DW-1:0] freeHead,
  output logic [DW-1:0] rdIdxA,
  output logic [DW-1:0] rdIdxB,
  output dpStrobe_t     strb,
  output logic          rspValid,
  output logic          rspHit,
  output logic [DW-1:0] rspIdx,
  output scbEntry_t     rspEnt,
  output logic          pageOutValid,
  output logic [DW-1:0] pageOutTag
);

  localparam int STEP_W = $clog2(NUM_ENTRIES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_SRCH, ST_UNLINK} state_e;

  state_e            state;
  logic [2:0]        opQ;
  logic [DW-1:0]     idxQ, tagQ, identQ, ctrlQ, cursor;
  logic [STEP_W-1:0] steps;

  // decisions of the current cycle
  logic          done, doneHit, goSearch, goPage, advance;
  logic [DW-1:0] doneIdx;
  logic          isMatch;

  assign cmdReady = (state == ST_IDLE);
  assign rdIdxA   = (state == ST_SRCH) ? cursor : idxQ;
  assign rdIdxB   = (freeHead != NULL_IDX) ? freeHead : discHead;

  assign isMatch = (tagQ == NULL_IDX) ? (rdEntA.ident == identQ)
                                      : (rdEntA.tag == tagQ);

  // Unlink of the entry on read port A, index idxQ.
  function automatic dpStrobe_t unlinkStrobes(input scbEntry_t e);
    dpStrobe_t s;
    s = '0;
    if (e.next != NULL_IDX) begin
      s.linkAEn     = 1'b1;
      s.linkAIsNext = 1'b0;
      s.linkAIdx    = e.next;
      s.linkAVal    = e.prev;
    end
    if (e.prev == NULL_IDX) begin
      s.discHeadWr  = 1'b1;
      s.discHeadVal = e.next;
    end else begin
      s.linkBEn     = 1'b1;
      s.linkBIsNext = 1'b1;
      s.linkBIdx    = e.prev;
      s.linkBVal    = e.next;
    end
    return s;
  endfunction

  always_comb begin
    strb     = '0;
    done     = 1'b0;
    doneHit  = 1'b0;
    doneIdx  = NULL_IDX;
    goSearch = 1'b0;
    goPage   = 1'b0;
    advance  = 1'b0;
    unique case (state)
      ST_EXEC: begin
        unique case (opQ)
          OP_INSERT: begin
            strb.entWr        = 1'b1;
            strb.entIdx       = idxQ;
            strb.entVal.tag   = tagQ;
            strb.entVal.ident = identQ;
            strb.entVal.ctrl  = ctrlQ;
            strb.entVal.next  = discHead;
            strb.entVal.prev  = NULL_IDX;
            if (discHead != NULL_IDX) begin
              strb.linkAEn     = 1'b1;
              strb.linkAIsNext = 1'b0;
              strb.linkAIdx    = discHead;
              strb.linkAVal    = idxQ;
            end
            strb.discHeadWr  = 1'b1;
            strb.discHeadVal = idxQ;
            done = 1'b1; doneHit = 1'b1; doneIdx = idxQ;
          end
          OP_REMOVE: begin
            strb = unlinkStrobes(rdEntA);
            done = 1'b1; doneHit = 1'b1; doneIdx = idxQ;
          end
          OP_FREE: begin
            strb.linkAEn     = 1'b1;
            strb.linkAIsNext = 1'b1;
            strb.linkAIdx    = idxQ;
            strb.linkAVal    = freeHead;
            strb.tagWr       = 1'b1;
            strb.tagIdx      = idxQ;
            strb.tagVal      = NULL_IDX;
            strb.freeHeadWr  = 1'b1;
            strb.freeHeadVal = idxQ;
            done = 1'b1; doneHit = 1'b1; doneIdx = idxQ;
          end
          OP_ALLOC: begin
            if (freeHead != NULL_IDX) begin
              strb.freeHeadWr  = 1'b1;
              strb.freeHeadVal = rdEntB.next;
              done = 1'b1; doneHit = 1'b1; doneIdx = freeHead;
            end else if (discHead != NULL_IDX) begin
              goPage = 1'b1;
            end else begin
              done = 1'b1;
            end
          end
          OP_READ: begin
            done = 1'b1; doneHit = 1'b1; doneIdx = idxQ;
          end
          OP_SEARCH: begin
            if (idxQ == NULL_IDX) done = 1'b1;
            else                  goSearch = 1'b1;
          end
          default: done = 1'b1;
        endcase
      end
      ST_UNLINK: begin
        strb = unlinkStrobes(rdEntA);
        done = 1'b1; doneHit = 1'b1; doneIdx = idxQ;
      end
      ST_SRCH: begin
        if (isMatch) begin
          done = 1'b1; doneHit = 1'b1; doneIdx = cursor;
        end else if (rdEntA.next == NULL_IDX ||
                     steps == STEP_W'(NUM_ENTRIES - 1)) begin
          done = 1'b1;
        end else begin
          advance = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      opQ          <= '0;
      idxQ         <= NULL_IDX;
      tagQ         <= NULL_IDX;
      identQ       <= NULL_IDX;
      ctrlQ        <= '0;
      cursor       <= NULL_IDX;
      steps        <= '0;
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspIdx       <= NULL_IDX;
      rspEnt       <= '0;
      pageOutValid <= 1'b0;
      pageOutTag   <= NULL_IDX;
    end else begin
      rspValid     <= 1'b0;
      pageOutValid <= 1'b0;
      if (state == ST_IDLE && cmdValid) begin
        opQ    <= cmdOp;
        idxQ   <= cmdIdx;
        tagQ   <= cmdTag;
        identQ <= cmdIdent;
        ctrlQ  <= cmdCtrl;
        state  <= ST_EXEC;
      end
      if (goSearch) begin
        cursor <= idxQ;
        steps  <= '0;
        state  <= ST_SRCH;
      end
      if (advance) begin
        cursor <= rdEntA.next;
        steps  <= steps + 1'b1;
      end
      if (goPage) begin
        pageOutValid <= 1'b1;
        pageOutTag   <= rdEntB.tag;
        idxQ         <= discHead;
        state        <= ST_UNLINK;
      end
      if (done) begin
        rspValid <= 1'b1;
        rspHit   <= doneHit;
        rspIdx   <= doneIdx;
        rspEnt   <= rdEntA;
        state    <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/scb_list_mgr.sv
module scb_list_mgr
  import scb_list_pkg::*;
#(
  parameter int            NUM_ENTRIES = 16,
  parameter logic [DW-1:0] NULL_IDX    = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic [2:0]    cmdOp,
  input  logic [DW-1:0] cmdIdx,
  input  logic [DW-1:0] cmdTag,
  input  logic [DW-1:0] cmdIdent,
  input  logic [DW-1:0] cmdCtrl,
  output logic          rspValid,
  output logic          rspHit,
  output logic [DW-1:0] rspIdx,
  output logic [DW-1:0] rspTag,
  output logic [DW-1:0] rspIdent,
  output logic [DW-1:0] rspCtrl,
  output logic [DW-1:0] rspNext,
  output logic [DW-1:0] rspPrev,
  output logic          pageOutValid,
  output logic [DW-1:0] pageOutTag,
  output logic [DW-1:0] discHeadOut,
  output logic [DW-1:0] freeHeadOut
);

  dpStrobe_t     strb;
  scbEntry_t     rdEntA, rdEntB, rspEnt;
  logic [DW-1:0] rdIdxA, rdIdxB;

  scb_table #(.NUM_ENTRIES(NUM_ENTRIES), .NULL_IDX(NULL_IDX)) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdIdxA   (rdIdxA),
    .rdIdxB   (rdIdxB),
    .rdEntA   (rdEntA),
    .rdEntB   (rdEntB),
    .discHead (discHeadOut),
    .freeHead (freeHeadOut)
  );

  scb_list_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .NULL_IDX(NULL_IDX)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .cmdOp        (cmdOp),
    .cmdIdx       (cmdIdx),
    .cmdTag       (cmdTag),
    .cmdIdent     (cmdIdent),
    .cmdCtrl      (cmdCtrl),
    .rdEntA       (rdEntA),
    .rdEntB       (rdEntB),
    .discHead     (discHeadOut),
    .freeHead     (freeHeadOut),
    .rdIdxA       (rdIdxA),
    .rdIdxB       (rdIdxB),
    .strb         (strb),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspIdx       (rspIdx),
    .rspEnt       (rspEnt),
    .pageOutValid (pageOutValid),
    .pageOutTag   (pageOutTag)
  );

  assign rspTag   = rspEnt.tag;
  assign rspIdent = rspEnt.ident;
  assign rspCtrl  = rspEnt.ctrl;
  assign rspNext  = rspEnt.next;
  assign rspPrev  = rspEnt.prev;

endmodule

// File: rtl/scb_list_mgr_chk.sv
module scb_list_mgr_chk
  import scb_list_pkg::*;
#(
  parameter int            NUM_ENTRIES = 16,
  parameter logic [DW-1:0] NULL_IDX    = '1
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic          cmdReady,
  input logic [2:0]    cmdOp,
  input logic [DW-1:0] cmdIdx,
  input logic          rspValid,
  input logic          rspHit,
  input logic [DW-1:0] rspIdx,
  input logic          pageOutValid,
  input logic [DW-1:0] discHeadOut
);

  localparam int CNT_W = $clog2(NUM_ENTRIES + 8);

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (cmdReady)  busyCnt <= '0;
    else                busyCnt <= busyCnt + 1'b1;
  end

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R3
  insert_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == 3'd0) |=> ##1 (discHeadOut == $past(cmdIdx, 2)));

  // R11
  pageout_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageOutValid |=> (rspValid && rspHit));

  // R7
  miss_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspIdx == NULL_IDX));

  // R8
  bounded_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(NUM_ENTRIES + 2));

endmodule

bind scb_list_mgr scb_list_mgr_chk #(.NUM_ENTRIES(NUM_ENTRIES), .NULL_IDX(NULL_IDX)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdValid     (cmdValid),
  .cmdReady     (cmdReady),
  .cmdOp        (cmdOp),
  .cmdIdx       (cmdIdx),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspIdx       (rspIdx),
  .pageOutValid (pageOutValid),
  .discHeadOut  (discHeadOut)
);

// File: tb/scb_list_mgr_tb.sv
`timescale 1ns/1ps
module scb_list_mgr_tb;

  localparam logic [7:0] NL = 8'hFF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdReady;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdIdx = '0, cmdTag = '0, cmdIdent = '0, cmdCtrl = '0;
  logic       rspValid, rspHit, pageOutValid;
  logic [7:0] rspIdx, rspTag, rspIdent, rspCtrl, rspNext, rspPrev;
  logic [7:0] pageOutTag, discHeadOut, freeHeadOut;

  int checks = 0;
  int errors = 0;

  // captured results of the last command
  logic       rHit;
  logic [7:0] rIdx, rTag, rNext, rPrev, rCtrl;
  int         rCyc, pageCyc;
  logic [7:0] pageTag;
  logic       readyAfterAccept;

  always #2 clk = ~clk;

  scb_list_mgr u_dut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdTag(cmdTag), .cmdIdent(cmdIdent), .cmdCtrl(cmdCtrl),
    .rspValid(rspValid), .rspHit(rspHit), .rspIdx(rspIdx),
    .rspTag(rspTag), .rspIdent(rspIdent), .rspCtrl(rspCtrl),
    .rspNext(rspNext), .rspPrev(rspPrev),
    .pageOutValid(pageOutValid), .pageOutTag(pageOutTag),
    .discHeadOut(discHeadOut), .freeHeadOut(freeHeadOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [7:0] idx,
                       input logic [7:0] tag, input logic [7:0] ident,
                       input logic [7:0] ctl);
    bit got;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIdx = idx;
    cmdTag = tag; cmdIdent = ident; cmdCtrl = ctl;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    readyAfterAccept = cmdReady;
    rCyc = 1; pageCyc = 0; pageTag = NL; got = 0;
    for (int n = 0; n < 100 && !got; n++) begin
      if (pageOutValid) begin pageCyc = rCyc; pageTag = pageOutTag; end
      if (rspValid) begin
        got = 1;
        rHit = rspHit; rIdx = rspIdx; rTag = rspTag;
        rNext = rspNext; rPrev = rspPrev; rCtrl = rspCtrl;
      end else begin
        @(negedge clk);
        rCyc++;
      end
    end
    if (!got) chk("R2", "response missing", 0, 1);
  endtask

  task automatic readEnt(input logic [7:0] idx);
    doCmd(3'd5, idx, 8'h00, 8'h00, 8'h00);
    chk("R13", "read hit", rHit, 1);
  endtask

  task automatic tResetState();
    chk("R1", "disc head after reset", discHeadOut, NL);
    chk("R1", "free head after reset", freeHeadOut, 0);
    readEnt(8'd3);
    chk("R1", "entry 3 next", rNext, 4);
    readEnt(8'd15);
    chk("R1", "last entry next", rNext, NL);
    chk("R13", "last entry prev", rPrev, NL);
  endtask

  task automatic tAllocFree();
    for (int i = 0; i < 3; i++) begin
      doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
      chk("R10", "alloc idx", rIdx, i);
      chk("R10", "alloc hit", rHit, 1);
      chk("R2", "ready low while busy", readyAfterAccept, 0);
      chk("R2", "simple op latency", rCyc, 2);
    end
    chk("R10", "free head advanced", freeHeadOut, 3);
  endtask

  task automatic tInsert();
    doCmd(3'd0, 8'd0, 8'h10, 8'h21, 8'hA0);
    doCmd(3'd0, 8'd1, 8'h11, 8'h22, 8'hA1);
    doCmd(3'd0, 8'd2, 8'h12, 8'h21, 8'hA2);
    chk("R3", "disc head", discHeadOut, 2);
    readEnt(8'd2);
    chk("R3", "new head prev", rPrev, NL);
    chk("R3", "new head next", rNext, 1);
    chk("R3", "new head ctrl", rCtrl, 8'hA2);
    readEnt(8'd1);
    chk("R3", "middle prev", rPrev, 2);
    chk("R3", "middle next", rNext, 0);
    readEnt(8'd0);
    chk("R3", "tail prev", rPrev, 1);
    chk("R3", "tail tag", rTag, 8'h10);
  endtask

  task automatic tSearch();
    doCmd(3'd2, 8'd2, NL, 8'h21, 8'h00);
    chk("R5", "ident search at start", rIdx, 2);
    chk("R8", "match at first entry latency", rCyc, 3);
    doCmd(3'd2, 8'd1, NL, 8'h21, 8'h00);
    chk("R5", "ident search from middle", rIdx, 0);
    chk("R5", "ident search hit", rHit, 1);
    doCmd(3'd2, 8'd2, 8'h11, 8'h21, 8'h00);
    chk("R6", "tag search ignores ident", rIdx, 1);
    chk("R8", "match at second entry latency", rCyc, 4);
    doCmd(3'd2, 8'd2, 8'h55, 8'h21, 8'h00);
    chk("R7", "tag miss idx", rIdx, NL);
    chk("R7", "tag miss hit", rHit, 0);
    chk("R8", "full walk latency", rCyc, 5);
    doCmd(3'd2, NL, 8'h10, 8'h21, 8'h00);
    chk("R7", "null start idx", rIdx, NL);
    chk("R7", "null start hit", rHit, 0);
  endtask

  task automatic tRemove();
    doCmd(3'd1, 8'd1, 8'h00, 8'h00, 8'h00);
    chk("R4", "head kept on middle remove", discHeadOut, 2);
    readEnt(8'd2);
    chk("R4", "predecessor next", rNext, 0);
    readEnt(8'd0);
    chk("R4", "successor prev", rPrev, 2);
    doCmd(3'd1, 8'd2, 8'h00, 8'h00, 8'h00);
    chk("R4", "head after head remove", discHeadOut, 0);
    readEnt(8'd0);
    chk("R4", "new head prev", rPrev, NL);
  endtask

  task automatic tFreePush();
    doCmd(3'd3, 8'd1, 8'h00, 8'h00, 8'h00);
    chk("R9", "free head", freeHeadOut, 1);
    readEnt(8'd1);
    chk("R9", "freed tag", rTag, NL);
    chk("R9", "freed next", rNext, 3);
    doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R10", "realloc pushed entry", rIdx, 1);
  endtask

  task automatic tDrainAndFallback();
    for (int i = 3; i < 16; i++) begin
      doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
      chk("R10", "drain alloc", rIdx, i);
      chk("R10", "drain no page-out", pageCyc, 0);
    end
    chk("R10", "free stack empty", freeHeadOut, NL);
    doCmd(3'd0, 8'd2, 8'h42, 8'h30, 8'h00);
    doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R11", "fallback idx", rIdx, 2);
    chk("R11", "fallback hit", rHit, 1);
    chk("R11", "page-out tag", pageTag, 8'h42);
    chk("R11", "page-out cycle before response", rCyc - pageCyc, 1);
    chk("R11", "head after unlink", discHeadOut, 0);
    readEnt(8'd0);
    chk("R11", "remaining prev", rPrev, NL);
    doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R11", "second fallback idx", rIdx, 0);
    chk("R11", "second page-out tag", pageTag, 8'h10);
    chk("R11", "disc list empty", discHeadOut, NL);
    doCmd(3'd4, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R12", "both empty idx", rIdx, NL);
    chk("R12", "both empty hit", rHit, 0);
    chk("R12", "no page-out", pageCyc, 0);
  endtask

  task automatic tBadOp();
    doCmd(3'd7, 8'd4, 8'h00, 8'h00, 8'h00);
    chk("R2", "bad opcode idx", rIdx, NL);
    chk("R2", "bad opcode hit", rHit, 0);
    chk("R2", "bad opcode free head", freeHeadOut, NL);
    chk("R2", "bad opcode disc head", discHeadOut, NL);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tAllocFree();
    tInsert();
    tSearch();
    tRemove();
    tFreePush();
    tDrainAndFallback();
    tBadOp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule